// File: doc/BRIEF.md
# Dual Comparator Control and Status Logic

This block holds the digital side of two voltage comparators. Each channel takes a raw one-bit compare result from the analog front end and brings it into the system clock domain. It then applies enable gating and polarity, and latches the result once per cycle as a status bit. From that result it drives a timer-facing output and a pin. It also detects rising and falling transitions and holds them in a sticky interrupt flag. The select codes for the analog input multiplexers and a connect indication are driven out to the front end. The block stores the speed and hysteresis settings but does not act on them.

Software reaches the block through a plain register port. A write takes effect on any clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The port never stalls, so it has no valid/ready pair and no back-pressure. Channel n has its first control word at address 2n and its second at 2n+1. The shared read-only mirror word sits at address 2·NUM_CH, which is 4 by default. The timer output can follow the conditioned result directly. It can instead be re-captured when the timer clock falls, so that a counter stepping on the rising edge never sees a change at the same moment.

Top module: `cmp_ctrl_top`

## Requirements
- R1: After reset, each channel's first control word reads 0x04, the second control word reads 0x00, the mirror reads 0x00, and every flag and irq is 0.
- R2: First control word bits: 7 enable, 6 result (read-only), 5 pin enable, 4 polarity, 3 reads 0, 2 speed, 1 hysteresis, 0 timer-sync. Second control word bits: 7 rising-edge enable, 6 falling-edge enable, 5:4 positive select, 3:2 read 0, 1:0 negative select. Writes to bit 6 of the first word and to all unused bits have no effect.
- R3: The raw input passes through two synchronizing flops. The conditioned result is (enable AND raw) XOR polarity, so a disabled channel outputs its polarity bit. The result bit reads this value one cycle after it forms.
- R4: The mirror word holds channel 1's result in bit 1 and channel 0's result in bit 0. All other mirror bits read 0, and writes to the mirror address are ignored.
- R5: `pin_oe` is high exactly when pin enable and `pin_dir_out` are both set, whatever the enable bit is. `pin_val` carries the timer-facing output while `pin_oe` is high and is 0 otherwise.
- R6: With timer-sync clear, `tmr_out` equals the conditioned result in the cycle that result forms.
- R7: With timer-sync set, `tmr_out` changes only on a falling edge of `tmr_clk` seen in the system clock domain, where it takes the conditioned result.
- R8: A 0-to-1 change of the result sets the flag when rising-edge enable is set. A 1-to-0 change sets it when falling-edge enable is set. Otherwise the flag holds.
- R9: Toggling polarity or enable sets the flag through the same edge logic, including while the channel is disabled.
- R10: A one-cycle `flag_clr` strobe clears the flag. An edge in the same cycle as the strobe leaves the flag set.
- R11: `irq` is the flag ANDed with that channel's `irq_en`.
- R12: `pos_sel` and `neg_sel` present the select fields, 2 bits per channel with channel n at bits 2n+1:2n. `mux_connect` equals the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| raw_cmp | input | 2 | Raw compare result per channel, asynchronous |
| tmr_clk | input | 1 | Timer source clock, asynchronous |
| pin_dir_out | input | 2 | Pin direction per channel, 1 = output |
| flag_clr | input | 2 | Write-one-to-clear strobe for each flag |
| irq_en | input | 2 | Interrupt enable per channel |
| tmr_out | output | 2 | Result sent to the timer |
| pin_val | output | 2 | Pin data |
| pin_oe | output | 2 | Pin drive enable |
| flag | output | 2 | Sticky interrupt flag |
| irq | output | 2 | Interrupt request |
| pos_sel | output | 4 | Positive mux select, 2 bits per channel |
| neg_sel | output | 4 | Negative mux select, 2 bits per channel |
| mux_connect | output | 2 | Input mux connected (enable) |

## Verification
The conditioning path is swept over every mix of enable, polarity and raw level on both channels. Each point is read back through the result bit, the mirror and the unsynchronized timer output, which separates gating from inversion. The pin path is swept over pin enable, direction and enable to show that enable plays no part in it. The edge logic is tried with all four rising/falling enable pairs against both edge directions. It is also tried with polarity and enable toggles on a disabled channel, and with a flag clear that lands in the same cycle as a new edge. The timer-sync capture is tried with the raw input moving while the timer clock holds high and then low, which shows that only the falling edge moves the output.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic on;
    logic oe;
    logic pol;
    logic spd;
    logic hys;
    logic syn;
  } ctrl0_t;

  typedef struct packed {
    logic       rise_en;
    logic       fall_en;
    logic [1:0] psel;
    logic [1:0] nsel;
  } ctrl1_t;

  localparam ctrl0_t CTRL0_RST = '{on: 1'b0, oe: 1'b0, pol: 1'b0, spd: 1'b1, hys: 1'b0, syn: 1'b0};
  localparam ctrl1_t CTRL1_RST = '{rise_en: 1'b0, fall_en: 1'b0, psel: 2'b00, nsel: 2'b00};

  function automatic logic [REG_W-1:0] pack_c0(ctrl0_t c, logic st);
    return {c.on, st, c.oe, c.pol, 1'b0, c.spd, c.hys, c.syn};
  endfunction

  function automatic ctrl0_t unpack_c0(logic [REG_W-1:0] w);
    return '{on: w[7], oe: w[5], pol: w[4], spd: w[2], hys: w[1], syn: w[0]};
  endfunction

  function automatic logic [REG_W-1:0] pack_c1(ctrl1_t c);
    return {c.rise_en, c.fall_en, c.psel, 2'b00, c.nsel};
  endfunction

  function automatic ctrl1_t unpack_c1(logic [REG_W-1:0] w);
    return '{rise_en: w[7], fall_en: w[6], psel: w[5:4], nsel: w[1:0]};
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_tclk_edge.sv
module cmp_tclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk,
  output logic tclk_fall
);
  logic tclk_s;
  logic tclk_prev;

  cmp_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(tclk), .q(tclk_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tclk_prev <= 1'b0;
    else        tclk_prev <= tclk_s;
  end

  assign tclk_fall = tclk_prev & ~tclk_s;

  assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_fall |=> !tclk_fall);
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_c0,
  input  logic             wr_c1,
  input  logic [REG_W-1:0] wdata,
  input  logic             raw_s,
  input  logic             tclk_fall,
  input  logic             pin_dir,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [REG_W-1:0] rd_c0,
  output logic [REG_W-1:0] rd_c1,
  output logic             status,
  output logic             tmr_out,
  output logic             pin_val,
  output logic             pin_oe,
  output logic             flag,
  output logic             irq,
  output logic [1:0]       psel,
  output logic [1:0]       nsel,
  output logic             connect
);
  ctrl0_t c0;
  ctrl1_t c1;
  logic   cond;
  logic   status_q;
  logic   sync_q;
  logic   flag_q;
  logic   ext;
  logic   rise;
  logic   fall;
  logic   edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0 <= CTRL0_RST;
      c1 <= CTRL1_RST;
    end else begin
      if (wr_c0) c0 <= unpack_c0(wdata);
      if (wr_c1) c1 <= unpack_c1(wdata);
    end
  end

  // gate before polarity: a disabled channel reports its polarity bit
  assign cond = (c0.on & raw_s) ^ c0.pol;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= cond;
  end

  assign rise     = cond & ~status_q;
  assign fall     = ~cond & status_q;
  assign edge_hit = (rise & c1.rise_en) | (fall & c1.fall_en);

  // a fresh edge outranks the clear strobe
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= edge_hit | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sync_q <= 1'b0;
    else if (tclk_fall) sync_q <= cond;
  end

  assign ext     = c0.syn ? sync_q : cond;
  assign tmr_out = ext;
  assign pin_oe  = c0.oe & pin_dir;
  assign pin_val = pin_oe & ext;
  assign status  = status_q;
  assign flag    = flag_q;
  assign irq     = flag_q & irq_en;
  assign psel    = c1.psel;
  assign nsel    = c1.nsel;
  assign connect = c0.on;
  assign rd_c0   = pack_c0(c0, status_q);
  assign rd_c1   = pack_c1(c1);

  assert_off_follows_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !c0.on |=> (status_q == $past(c0.pol)));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(c1.rise_en) || $past(c1.fall_en)));
  assert_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tclk_fall |=> $stable(sync_q));
endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top
  import cmp_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * NUM_CH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_CH-1:0]   raw_cmp,
  input  logic                tmr_clk,
  input  logic [NUM_CH-1:0]   pin_dir_out,
  input  logic [NUM_CH-1:0]   flag_clr,
  input  logic [NUM_CH-1:0]   irq_en,
  output logic [NUM_CH-1:0]   tmr_out,
  output logic [NUM_CH-1:0]   pin_val,
  output logic [NUM_CH-1:0]   pin_oe,
  output logic [NUM_CH-1:0]   flag,
  output logic [NUM_CH-1:0]   irq,
  output logic [2*NUM_CH-1:0] pos_sel,
  output logic [2*NUM_CH-1:0] neg_sel,
  output logic [NUM_CH-1:0]   mux_connect
);
  localparam logic [ADDR_W-1:0] MIRROR_ADDR = ADDR_W'(2 * NUM_CH);

  logic [NUM_CH-1:0] raw_s;
  logic [NUM_CH-1:0] status;
  logic              tclk_fall;
  logic [REG_W-1:0]  rd0 [NUM_CH];
  logic [REG_W-1:0]  rd1 [NUM_CH];

  cmp_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_raw_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_cmp), .q(raw_s)
  );

  cmp_tclk_edge #(.STAGES(SYNC_STAGES)) u_tclk (
    .clk(clk), .rst_n(rst_n), .tclk(tmr_clk), .tclk_fall(tclk_fall)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic wr0;
    logic wr1;
    assign wr0 = bus_wr && (bus_addr == ADDR_W'(2 * n));
    assign wr1 = bus_wr && (bus_addr == ADDR_W'(2 * n + 1));

    cmp_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_c0(wr0), .wr_c1(wr1), .wdata(bus_wdata),
      .raw_s(raw_s[n]), .tclk_fall(tclk_fall),
      .pin_dir(pin_dir_out[n]), .flag_clr(flag_clr[n]), .irq_en(irq_en[n]),
      .rd_c0(rd0[n]), .rd_c1(rd1[n]), .status(status[n]),
      .tmr_out(tmr_out[n]), .pin_val(pin_val[n]), .pin_oe(pin_oe[n]),
      .flag(flag[n]), .irq(irq[n]),
      .psel(pos_sel[2*n +: 2]), .nsel(neg_sel[2*n +: 2]),
      .connect(mux_connect[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(2 * n))     bus_rdata = rd0[n];
      if (bus_addr == ADDR_W'(2 * n + 1)) bus_rdata = rd1[n];
    end
    if (bus_addr == MIRROR_ADDR) bus_rdata[NUM_CH-1:0] = status;
  end

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flag) == '0);
endmodule

// File: tb/cmp_ctrl_top_test.sv
module cmp_ctrl_top_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] raw_cmp = 0;
  logic       tmr_clk = 0;
  logic [1:0] pin_dir_out = 0;
  logic [1:0] flag_clr = 0;
  logic [1:0] irq_en = 0;
  logic [1:0] tmr_out, pin_val, pin_oe, flag, irq, mux_connect;
  logic [3:0] pos_sel, neg_sel;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_cmp(raw_cmp),
    .tmr_clk(tmr_clk), .pin_dir_out(pin_dir_out), .flag_clr(flag_clr),
    .irq_en(irq_en), .tmr_out(tmr_out), .pin_val(pin_val), .pin_oe(pin_oe),
    .flag(flag), .irq(irq), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .mux_connect(mux_connect)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clr(input int ch);
    @(negedge clk);
    flag_clr[ch] = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    rd(0, d); chk("R1 c0 ch0", d, 8'h04);
    rd(1, d); chk("R1 c1 ch0", d, 8'h00);
    rd(2, d); chk("R1 c0 ch1", d, 8'h04);
    rd(3, d); chk("R1 c1 ch1", d, 8'h00);
    rd(4, d); chk("R1 mirror", d, 8'h00);
    chk("R1 flag", {6'b0, flag}, 8'h00);
    chk("R1 irq", {6'b0, irq}, 8'h00);

    // R2 layout, ignored bits (raw=0, pol=1, on=1 -> result 1)
    wr(0, 8'hFF); wait_n(2);
    rd(0, d); chk("R2 c0 all ones", d, 8'hF7);
    wr(0, 8'h00); wait_n(2);
    rd(0, d); chk("R2 c0 zero", d, 8'h00);
    wr(1, 8'hFF);
    rd(1, d); chk("R2 c1 all ones", d, 8'hF3);
    wr(1, 8'h00);
    clr(0);

    // R4 write to mirror ignored
    wr(4, 8'hFF); wait_n(2);
    rd(4, d); chk("R4 mirror write ignored", d, 8'h00);
    rd(0, d); chk("R4 no side effect", d, 8'h00);

    // R3/R4/R6 sweep: enable, polarity, raw per channel
    for (int ch = 0; ch < 2; ch++)
      for (int on = 0; on < 2; on++)
        for (int pol = 0; pol < 2; pol++)
          for (int raw = 0; raw < 2; raw++) begin
            logic e;
            e = ((on & raw) ^ pol) != 0;
            wr(3'(2*ch), {on[0], 2'b00, pol[0], 4'b0100});
            raw_cmp[ch] = raw[0];
            wait_n(4);
            rd(3'(2*ch), d); chk("R3 result bit", {7'b0, d[6]}, {7'b0, e});
            rd(4, d); chk("R4 mirror bit", {7'b0, d[ch]}, {7'b0, e});
            chk("R6 tmr_out async", {7'b0, tmr_out[ch]}, {7'b0, e});
            chk("R12 connect", {7'b0, mux_connect[ch]}, {7'b0, on[0]});
            rd(4, d); chk("R4 mirror upper", {2'b0, d[7:2]}, 8'h00);
          end
    raw_cmp = 0;
    wr(0, 8'h04); wr(2, 8'h04); wait_n(4);
    clr(0); clr(1);

    // R5 pin sweep on ch1 (raw=1, pol=0)
    raw_cmp[1] = 1;
    for (int on = 0; on < 2; on++)
      for (int oe = 0; oe < 2; oe++)
        for (int dir = 0; dir < 2; dir++) begin
          logic eo;
          eo = (oe & dir) != 0;
          wr(2, {on[0], 1'b0, oe[0], 5'b00100});
          pin_dir_out[1] = dir[0];
          wait_n(4);
          chk("R5 pin_oe", {7'b0, pin_oe[1]}, {7'b0, eo});
          chk("R5 pin_val", {7'b0, pin_val[1]}, {7'b0, eo & (on != 0)});
        end
    raw_cmp = 0; pin_dir_out = 0;
    wr(2, 8'h04); wait_n(4); clr(1);

    // R12 mux select sweep on ch0
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++) begin
        wr(1, {2'b00, p[1:0], 2'b00, q[1:0]});
        chk("R12 pos_sel", {6'b0, pos_sel[1:0]}, 8'(p));
        chk("R12 neg_sel", {6'b0, neg_sel[1:0]}, 8'(q));
        chk("R12 ch1 untouched", {4'b0, pos_sel[3:2], neg_sel[3:2]}, 8'h00);
      end
    wr(1, 8'h00);

    // R8 edge enables sweep on ch0
    wr(0, 8'h84); wait_n(4); clr(0);
    for (int ip = 0; ip < 2; ip++)
      for (int in_ = 0; in_ < 2; in_++) begin
        wr(1, {ip[0], in_[0], 6'b0});
        raw_cmp[0] = 1; wait_n(4);
        chk("R8 rising edge", {7'b0, flag[0]}, 8'(ip));
        clr(0);
        raw_cmp[0] = 0; wait_n(4);
        chk("R8 falling edge", {7'b0, flag[0]}, 8'(in_));
        clr(0);
        chk("R10 cleared", {7'b0, flag[0]}, 8'h00);
      end

    // R9 toggles while disabled (ch1)
    wr(3, 8'hC0);
    wr(2, 8'h14); wait_n(2);
    chk("R9 pol toggle off", {7'b0, flag[1]}, 8'h01);
    clr(1);
    wr(2, 8'h04); wait_n(2);
    chk("R9 pol back off", {7'b0, flag[1]}, 8'h01);
    clr(1);
    raw_cmp[1] = 1; wait_n(4);
    chk("R9 raw ignored while off", {7'b0, flag[1]}, 8'h00);
    wr(2, 8'h84); wait_n(2);
    chk("R9 enable toggle", {7'b0, flag[1]}, 8'h01);
    raw_cmp[1] = 0; wait_n(4); clr(1);

    // R11 irq gating
    wr(0, 8'h84); wr(1, 8'hC0); raw_cmp[0] = 1; wait_n(4);
    irq_en = 0; #1;
    chk("R11 irq masked", {7'b0, irq[0]}, 8'h00);
    irq_en = 2'b01; #1;
    chk("R11 irq enabled", {7'b0, irq[0]}, 8'h01);

    // R10 edge beats clear in the same cycle
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h94;
    @(negedge clk);
    bus_wr = 0; flag_clr[0] = 1;
    @(negedge clk);
    flag_clr = 0;
    chk("R10 edge wins over clear", {7'b0, flag[0]}, 8'h01);
    clr(0);
    chk("R10 clear alone", {7'b0, flag[0]}, 8'h00);
    irq_en = 0; raw_cmp = 0;

    // R7 timer-synchronous capture on ch0
    wr(1, 8'h00); wr(0, 8'h85);
    tmr_clk = 1; wait_n(6);
    chk("R7 start", {7'b0, tmr_out[0]}, 8'h00);
    raw_cmp[0] = 1; wait_n(6);
    chk("R7 hold while high", {7'b0, tmr_out[0]}, 8'h00);
    tmr_clk = 0; wait_n(6);
    chk("R7 capture on fall", {7'b0, tmr_out[0]}, 8'h01);
    raw_cmp[0] = 0; wait_n(6);
    chk("R7 hold while low", {7'b0, tmr_out[0]}, 8'h01);
    tmr_clk = 1; wait_n(6);
    chk("R7 no capture on rise", {7'b0, tmr_out[0]}, 8'h01);
    tmr_clk = 0; wait_n(6);
    chk("R7 second fall", {7'b0, tmr_out[0]}, 8'h00);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule